// File: doc/BRIEF.md
# Three-wire serial EEPROM command master

This block sits on the host side of a three-wire serial EEPROM that holds 64 words of 16 bits. A requester presents one command at a time: a 2-bit opcode, a 6-bit word address and a 16-bit data word. The block raises chip select and divides the system clock down to a serial clock. It shifts out a frame that opens with a start bit of 1, then sends the opcode and the address, most significant bit first. The frame ends by sending 16 data bits, capturing 16 read bits, or stopping at the address, depending on the command.

Opcode 00 carries a second set of commands in the top two address bits: write enable, write disable, erase of the whole array and write of every word. Each command that programs the array is followed by a short chip-select-low gap. Chip select then goes high again and the block watches the data-in line until the device reports ready by driving it high. A hard cycle limit ends the wait with a timeout. The requester sees a one-cycle done pulse, a timeout flag that comes with that pulse, and the last word read.

Top module: `sereep_master`

## Requirements
- R1: After reset, and whenever no command is in progress, chip select, serial clock and data-out are low, and busy and done are low.
- R2: Every frame begins with a 1, followed by the opcode (2 bits) and the word address (6 bits), each MSB first. The device sees these 9 bits on the first 9 rising serial-clock edges.
- R3: Opcode 00 is decoded by address bits [5:4]: 11 = write enable, 00 = write disable, 10 = erase all, 01 = write all. Enable and disable send only the 9-bit header and are not programming commands. Erase-all and write-all are programming commands.
- R4: WRITE (opcode 01) and write-all send the 16 data bits D15 first, right after the header, for 25 serial clocks in all.
- R5: READ (opcode 10) gives 16 more serial clocks after the header. Data-in is sampled on rising edges 10 to 25, MSB first. The word is presented on rdata when done pulses.
- R6: Data-out changes only on a falling serial-clock edge (or when a command is accepted). The high and low phases of the serial clock each last HALF_DIV system clocks.
- R7: After a programming command (WRITE, ERASE = 11, erase-all, write-all), chip select stays low for CS_LOW_CYC system clocks and is then raised to poll.
- R8: While polling, done is not given before data-in is seen high. Once it is seen high, chip select drops and done pulses for one cycle with timeout low.
- R9: If data-in stays low for BUSY_LIMIT system clocks of polling, chip select drops, and done and timeout pulse together. The block is then idle and accepts the next command.
- R10: A request is accepted only when idle. Requests made while busy is high are ignored and cause no extra frame. Busy stays high from acceptance until the done pulse.
- R11: READ, write enable and write disable end with done once the frame ends, without raising chip select a second time, and never signal timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Command request, taken when idle |
| req_op | input | 2 | Opcode: 10 read, 01 write, 11 erase, 00 special |
| req_addr | input | 6 | Word address, or special-command selector in [5:4] |
| req_wdata | input | 16 | Data for write and write-all |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle pulse when the command ends |
| timeout | output | 1 | Pulses with done when ready was never seen |
| rdata | output | 16 | Word captured by the last READ |
| ee_cs | output | 1 | Chip select to the EEPROM |
| ee_sk | output | 1 | Serial clock to the EEPROM |
| ee_do | output | 1 | Serial data to the EEPROM |
| ee_di | input | 1 | Serial data and ready/busy from the EEPROM |

## Verification
A bit counter or length selector that is wrong shows up in the frame that the device model decodes when chip select falls. The model sees the wrong clock count, header or data on the same command. A fault in the poll or gap sequencing appears on that command's done. Done comes with no second chip-select raise, or with a chip-select low or high time that does not match the parameter, or timeout is set on a device that did report ready. A wrong capture order or shift direction shows up in rdata on the next READ of a word whose expected value the bench tracks from its own record of earlier commands.

// File: rtl/sereep_pkg.sv
package sereep_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SHIFT,
      ST_GAP,
      ST_POLL,
      ST_FIN
   } sereep_state_e;

   localparam logic [1:0] OPC_SPECIAL = 2'b00;
   localparam logic [1:0] OPC_WRITE   = 2'b01;
   localparam logic [1:0] OPC_READ    = 2'b10;
   localparam logic [1:0] OPC_ERASE   = 2'b11;

   localparam logic [1:0] SEL_WDIS    = 2'b00;
   localparam logic [1:0] SEL_WRALL   = 2'b01;
   localparam logic [1:0] SEL_ERALL   = 2'b10;
   localparam logic [1:0] SEL_WEN     = 2'b11;

   // command carries a data word after the header
   function automatic logic carries_word(input logic [1:0] op, input logic [1:0] sel);
      return (op == OPC_WRITE) || (op == OPC_SPECIAL && sel == SEL_WRALL);
   endfunction

   // command changes the array and therefore needs a ready poll
   function automatic logic programs_array(input logic [1:0] op, input logic [1:0] sel);
      return (op == OPC_WRITE) || (op == OPC_ERASE) ||
             (op == OPC_SPECIAL && (sel == SEL_WRALL || sel == SEL_ERALL));
   endfunction

endpackage

// File: rtl/sereep_divider.sv
module sereep_divider #(
   parameter int HALF_DIV = 125
)(
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic tick
);
   localparam int CW = $clog2(HALF_DIV + 1);

   logic [CW-1:0] cnt_q;
   logic          wrap;

   assign wrap = (cnt_q == CW'(HALF_DIV - 1));
   assign tick = en && wrap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q <= '0;
      else if (!en)     cnt_q <= '0;
      else if (wrap)    cnt_q <= '0;
      else              cnt_q <= cnt_q + CW'(1);
   end

   // R6: a phase never outlasts the divider period
   a_r6_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CW'(HALF_DIV - 1));
endmodule

// File: rtl/sereep_sync.sv
module sereep_sync #(
   parameter int STAGES = 2
)(
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES == 0) begin : g_direct
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[STAGES-2 >= 0 ? STAGES-2 : 0 : 0], d} >> ((STAGES == 1) ? 0 : 0);
         end
         assign q = chain_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/sereep_countdown.sv
module sereep_countdown #(
   parameter int W = 8
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         zero
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt_q <= '0;
      else if (load)         cnt_q <= load_val;
      else if (cnt_q != '0)  cnt_q <= cnt_q - W'(1);
   end

   assign zero = (cnt_q == '0);

   // R9: the window only shrinks between loads
   a_r9_count_down: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(load) && $past(cnt_q) != '0) |-> (cnt_q == $past(cnt_q) - W'(1)));
endmodule

// File: rtl/sereep_shifter.sv
module sereep_shifter #(
   parameter int OUT_W = 25,
   parameter int IN_W  = 16
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic [OUT_W-1:0] load_val,
   input  logic            shift_out,
   input  logic            shift_in,
   input  logic            in_bit,
   output logic            next_bit,
   output logic [IN_W-1:0] captured
);
   logic [OUT_W-1:0] out_q;
   logic [IN_W-1:0]  in_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         out_q <= '0;
      else if (load)      out_q <= load_val;
      else if (shift_out) out_q <= {out_q[OUT_W-2:0], 1'b0};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        in_q <= '0;
      else if (shift_in) in_q <= {in_q[IN_W-2:0], in_bit};
   end

   assign next_bit = out_q[OUT_W-2];
   assign captured = in_q;

   // R5: captured bits enter at the LSB and move up by one
   a_r5_capture_order: assert property (@(posedge clk) disable iff (!rst_n)
      $past(shift_in) |-> (in_q[IN_W-1:1] == $past(in_q[IN_W-2:0])));
endmodule

// File: rtl/sereep_master.sv
module sereep_master
   import sereep_pkg::*;
#(
   parameter int ADDR_W      = 6,
   parameter int DATA_W      = 16,
   parameter int HALF_DIV    = 125,
   parameter int CS_LOW_CYC  = 125,
   parameter int BUSY_LIMIT  = 3_000_000,
   parameter int SYNC_STAGES = 2
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [1:0]        req_op,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              busy,
   output logic              done,
   output logic              timeout,
   output logic [DATA_W-1:0] rdata,
   output logic              ee_cs,
   output logic              ee_sk,
   output logic              ee_do,
   input  logic              ee_di
);
   localparam int HDR_W   = 3 + ADDR_W;
   localparam int FRAME_W = HDR_W + DATA_W;
   localparam int CNT_W   = $clog2(FRAME_W + 1);
   localparam int TMR_MAX = (BUSY_LIMIT > CS_LOW_CYC) ? BUSY_LIMIT : CS_LOW_CYC;
   localparam int TMR_W   = $clog2(TMR_MAX + 1);

   generate
      if (HALF_DIV < 1)   begin : g_bad_div  $error("HALF_DIV must be at least 1");   end
      if (CS_LOW_CYC < 1) begin : g_bad_gap  $error("CS_LOW_CYC must be at least 1"); end
      if (BUSY_LIMIT < 1) begin : g_bad_lim  $error("BUSY_LIMIT must be at least 1"); end
      if (ADDR_W < 2)     begin : g_bad_addr $error("ADDR_W must be at least 2");     end
      if (DATA_W < 2)     begin : g_bad_data $error("DATA_W must be at least 2");     end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 3) begin : g_bad_sync
         $error("SYNC_STAGES must be 0 to 3");
      end
   endgenerate

   sereep_state_e     state_q;
   logic [1:0]        op_q;
   logic [ADDR_W-1:0] addr_q;
   logic [CNT_W-1:0]  bits_q, total_q, outn_q;
   logic              prog_q, rd_q, to_q;
   logic              cs_q, sk_q, do_q;
   logic [DATA_W-1:0] rdata_q;

   logic              tick, di_s, next_bit, tmr_zero;
   logic [DATA_W-1:0] captured;
   logic              accept, rise_ev, fall_ev, last_fall, cap_en, tmr_load;
   logic [TMR_W-1:0]  tmr_val;
   logic [1:0]        req_sel;

   assign req_sel   = req_addr[ADDR_W-1:ADDR_W-2];
   assign accept    = (state_q == ST_IDLE) && req_valid;
   assign rise_ev   = (state_q == ST_SHIFT) && tick && !sk_q;
   assign fall_ev   = (state_q == ST_SHIFT) && tick &&  sk_q;
   assign last_fall = fall_ev && (bits_q == total_q);
   assign cap_en    = rise_ev && rd_q && (bits_q >= CNT_W'(HDR_W));
   assign tmr_load  = last_fall || ((state_q == ST_GAP) && tmr_zero);
   assign tmr_val   = last_fall ? TMR_W'(CS_LOW_CYC - 1) : TMR_W'(BUSY_LIMIT - 1);

   sereep_divider #(.HALF_DIV(HALF_DIV)) i_div (
      .clk(clk), .rst_n(rst_n), .en(state_q == ST_SHIFT), .tick(tick));

   sereep_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk(clk), .rst_n(rst_n), .d(ee_di), .q(di_s));

   sereep_countdown #(.W(TMR_W)) i_tmr (
      .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero));

   sereep_shifter #(.OUT_W(FRAME_W), .IN_W(DATA_W)) i_shift (
      .clk(clk), .rst_n(rst_n),
      .load(accept), .load_val({1'b1, req_op, req_addr, req_wdata}),
      .shift_out(fall_ev && !last_fall), .shift_in(cap_en), .in_bit(di_s),
      .next_bit(next_bit), .captured(captured));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         op_q    <= '0;
         addr_q  <= '0;
         bits_q  <= '0;
         total_q <= '0;
         outn_q  <= '0;
         prog_q  <= 1'b0;
         rd_q    <= 1'b0;
         to_q    <= 1'b0;
         cs_q    <= 1'b0;
         sk_q    <= 1'b0;
         do_q    <= 1'b0;
         rdata_q <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  op_q    <= req_op;
                  addr_q  <= req_addr;
                  bits_q  <= '0;
                  prog_q  <= programs_array(req_op, req_sel);
                  rd_q    <= (req_op == OPC_READ);
                  to_q    <= 1'b0;
                  outn_q  <= carries_word(req_op, req_sel) ? CNT_W'(FRAME_W) : CNT_W'(HDR_W);
                  total_q <= (carries_word(req_op, req_sel) || req_op == OPC_READ)
                             ? CNT_W'(FRAME_W) : CNT_W'(HDR_W);
                  cs_q    <= 1'b1;
                  do_q    <= 1'b1;
                  state_q <= ST_SHIFT;
               end
            end
            ST_SHIFT: begin
               if (rise_ev) begin
                  sk_q   <= 1'b1;
                  bits_q <= bits_q + CNT_W'(1);
               end else if (fall_ev) begin
                  sk_q <= 1'b0;
                  if (last_fall) begin
                     cs_q    <= 1'b0;
                     do_q    <= 1'b0;
                     if (rd_q) rdata_q <= captured;
                     state_q <= prog_q ? ST_GAP : ST_FIN;
                  end else begin
                     do_q <= (bits_q < outn_q) ? next_bit : 1'b0;
                  end
               end
            end
            ST_GAP: begin
               if (tmr_zero) begin
                  cs_q    <= 1'b1;
                  state_q <= ST_POLL;
               end
            end
            ST_POLL: begin
               if (di_s) begin
                  cs_q    <= 1'b0;
                  state_q <= ST_FIN;
               end else if (tmr_zero) begin
                  cs_q    <= 1'b0;
                  to_q    <= 1'b1;
                  state_q <= ST_FIN;
               end
            end
            ST_FIN: begin
               state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy    = (state_q != ST_IDLE);
   assign done    = (state_q == ST_FIN);
   assign timeout = (state_q == ST_FIN) && to_q;
   assign rdata   = rdata_q;
   assign ee_cs   = cs_q;
   assign ee_sk   = sk_q;
   assign ee_do   = do_q;

   // R1: serial lines quiet while idle
   a_r1_idle_lines: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE) |-> (!ee_cs && !ee_sk));
   // R6: data-out holds while the serial clock is high
   a_r6_do_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (ee_sk && $past(ee_sk)) |-> $stable(ee_do));
   // R6: data-out moves only on a falling edge or at acceptance
   a_r6_do_edge: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ee_do) |-> ($fell(ee_sk) || $past(state_q == ST_IDLE)));
   // R7: chip select low through the gap
   a_r7_gap_low: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_GAP) |-> !ee_cs);
   // R8: done is a single-cycle pulse
   a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R9: timeout only alongside done
   a_r9_timeout_done: assert property (@(posedge clk) disable iff (!rst_n)
      timeout |-> done);
   // R10: the held command does not change while busy
   a_r10_hold_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_IDLE) |=> ($stable(op_q) && $stable(addr_q)));
   // R11: only programming commands reach the poll
   a_r11_no_poll: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_POLL) |-> (prog_q && ee_cs));
endmodule

// File: tb/test_sereep_master.sv
module test_sereep_master;
   localparam int HALF = 3;
   localparam int CSLOW = 5;
   localparam int BLIM = 400;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic [1:0] req_op = '0;
   logic [5:0] req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic busy, done, timeout, ee_cs, ee_sk, ee_do;
   logic [15:0] rdata;
   logic ee_di;

   always #2 clk = ~clk;

   sereep_master #(.HALF_DIV(HALF), .CS_LOW_CYC(CSLOW), .BUSY_LIMIT(BLIM)) i_sereep_master (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
      .timeout(timeout), .rdata(rdata), .ee_cs(ee_cs), .ee_sk(ee_sk),
      .ee_do(ee_do), .ee_di(ee_di));

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   // ---------------- device model ----------------
   int cyc = 0, nb = 0, sk_hi_start = 0, sk_bad = 0, do_bad = 0;
   int frames = 0, raises = 0, last_low = 0, last_hi = 0, last_nb = 0;
   int low_start = 0, hi_start = 0, bleft = 0, busy_cfg = 0;
   logic [24:0] sh = '0;
   logic [8:0] hdr = '0, last_hdr = '0;
   logic [15:0] last_data = '0;
   logic sk_p = 0, cs_p = 0, do_p = 0, wait_raise = 0, polling = 0, mwen = 0;
   logic [15:0] mmem [64];
   logic [15:0] exp_mem [64];
   logic exp_wen = 1'b0;

   function automatic logic [15:0] seed_word(input int i);
      return 16'(i * 16'h0911) ^ 16'h3C5A;
   endfunction

   function automatic bit f_prog(input logic [1:0] op, input logic [5:0] a);
      return op == 2'b01 || op == 2'b11 || (op == 2'b00 && (a[5:4] == 2'b10 || a[5:4] == 2'b01));
   endfunction

   function automatic bit f_word(input logic [1:0] op, input logic [5:0] a);
      return op == 2'b01 || (op == 2'b00 && a[5:4] == 2'b01);
   endfunction

   always @(negedge clk) begin
      cyc++;
      if (!rst_n) begin
         ee_di = 1'b0;
         nb = 0;
      end else begin
         if (ee_sk && !sk_p && ee_cs) begin
            sh = {sh[23:0], ee_do};
            nb++;
            sk_hi_start = cyc;
            if (nb == 9) hdr = sh[8:0];
            if (nb >= 9 && nb < 25 && hdr[7:6] == 2'b10) ee_di = mmem[hdr[5:0]][24-nb];
            else ee_di = 1'b0;
         end
         if (!ee_sk && sk_p && (cyc - sk_hi_start) != HALF) sk_bad++;
         if (ee_sk && sk_p && ee_do != do_p) do_bad++;
         if (!ee_cs && cs_p) begin
            ee_di = 1'b0;
            if (polling) begin
               polling = 0;
               last_hi = cyc - hi_start;
            end else if (nb > 0) begin
               frames++;
               last_nb = nb;
               last_hdr = hdr;
               last_data = sh[15:0];
               case (hdr[7:6])
                  2'b01: if (mwen) mmem[hdr[5:0]] = sh[15:0];
                  2'b11: if (mwen) mmem[hdr[5:0]] = 16'hFFFF;
                  2'b00: case (hdr[5:4])
                     2'b11: mwen = 1'b1;
                     2'b00: mwen = 1'b0;
                     2'b10: if (mwen) for (int i = 0; i < 64; i++) mmem[i] = 16'hFFFF;
                     default: if (mwen) for (int i = 0; i < 64; i++) mmem[i] = sh[15:0];
                  endcase
                  default: ;
               endcase
               if (f_prog(hdr[7:6], hdr[5:0])) begin
                  wait_raise = 1;
                  low_start = cyc;
               end
            end
            nb = 0;
         end else if (ee_cs && !cs_p) begin
            if (wait_raise) begin
               wait_raise = 0;
               polling = 1;
               raises++;
               last_low = cyc - low_start;
               hi_start = cyc;
               bleft = busy_cfg;
               ee_di = 1'b0;
            end else begin
               nb = 0;
            end
         end else if (polling) begin
            if (busy_cfg >= 0 && bleft == 0) ee_di = 1'b1;
            else if (bleft > 0) bleft--;
         end
      end
      sk_p = ee_sk;
      cs_p = ee_cs;
      do_p = ee_do;
   end

   // ---------------- checking ----------------
   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic run_cmd(input logic [1:0] op, input logic [5:0] a, input logic [15:0] wd,
                          input int bdelay, input int intrude_at);
      int f0, r0, n;
      bit got, to_seen;
      logic [8:0] xh;
      f0 = frames;
      r0 = raises;
      busy_cfg = bdelay;
      @(negedge clk);
      req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = wd;
      @(negedge clk);
      req_valid = 1'b0;
      got = 0; to_seen = 0; n = 0;
      while (!got && n < 5000) begin
         @(negedge clk);
         n++;
         if (n == intrude_at) begin
            chk(busy == 1'b1, "R10", "busy during command", 32'(busy), 1);
            req_valid = 1'b1; req_op = 2'b10; req_addr = ~a; req_wdata = ~wd;
         end else if (n == intrude_at + 1) begin
            req_valid = 1'b0;
         end
         if (done) begin got = 1; to_seen = timeout; end
      end
      req_valid = 1'b0;
      @(negedge clk);
      chk(got, "R10", "done seen", 32'(got), 1);
      chk(busy == 1'b0, "R10", "idle after done", 32'(busy), 0);
      chk(frames == f0 + 1, "R10", "frame count", 32'(frames - f0), 1);
      xh = {1'b1, op, a};
      chk(last_hdr == xh, op == 2'b00 ? "R3" : "R2", "header bits", 32'(last_hdr), 32'(xh));
      chk(last_nb == ((f_word(op, a) || op == 2'b10) ? 25 : 9), "R4", "clock count",
          32'(last_nb), (f_word(op, a) || op == 2'b10) ? 25 : 9);
      if (f_word(op, a)) chk(last_data == wd, "R4", "data word", 32'(last_data), 32'(wd));
      if (f_prog(op, a)) begin
         chk(raises == r0 + 1, "R7", "poll raise", 32'(raises - r0), 1);
         chk(last_low >= CSLOW, "R7", "cs low gap", 32'(last_low), CSLOW);
         if (bdelay >= 0) begin
            chk(!to_seen, "R8", "no timeout when ready", 32'(to_seen), 0);
            chk(last_hi > bdelay && last_hi <= bdelay + 8, "R8", "poll length",
                32'(last_hi), 32'(bdelay + 1));
         end else begin
            chk(to_seen, "R9", "timeout flag", 32'(to_seen), 1);
            chk(last_hi >= BLIM - 1 && last_hi <= BLIM + 1, "R9", "timeout window",
                32'(last_hi), BLIM);
         end
      end else begin
         chk(raises == r0, "R11", "no poll raise", 32'(raises - r0), 0);
         chk(!to_seen, "R11", "no timeout", 32'(to_seen), 0);
      end
      if (op == 2'b10) chk(rdata == exp_mem[a], "R5", "read word", 32'(rdata), 32'(exp_mem[a]));
      // reference update from the request itself
      case (op)
         2'b01: if (exp_wen) exp_mem[a] = wd;
         2'b11: if (exp_wen) exp_mem[a] = 16'hFFFF;
         2'b00: case (a[5:4])
            2'b11: exp_wen = 1'b1;
            2'b00: exp_wen = 1'b0;
            2'b10: if (exp_wen) for (int i = 0; i < 64; i++) exp_mem[i] = 16'hFFFF;
            default: if (exp_wen) for (int i = 0; i < 64; i++) exp_mem[i] = wd;
         endcase
         default: ;
      endcase
   endtask

   initial begin
      for (int i = 0; i < 64; i++) begin
         mmem[i] = seed_word(i);
         exp_mem[i] = seed_word(i);
      end
      void'($urandom(32'd20240611));
      repeat (4) @(negedge clk);
      chk(!ee_cs && !ee_sk && !ee_do, "R1", "lines in reset", {ee_cs, ee_sk, ee_do}, 0);
      chk(!busy && !done, "R1", "status in reset", {busy, done}, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(!ee_cs && !ee_sk && !busy, "R1", "idle after reset", {ee_cs, ee_sk, busy}, 0);

      // R3: writes disabled -> array unchanged
      run_cmd(2'b00, 6'b000000, 16'h0, 0, -1);
      run_cmd(2'b01, 6'd5, 16'hDEAD, 3, -1);
      run_cmd(2'b10, 6'd5, 16'h0, 0, -1);
      // enable, write, read back (R4, R5)
      run_cmd(2'b00, 6'b110000, 16'h0, 0, -1);
      run_cmd(2'b01, 6'd0, 16'hA5C3, 0, -1);
      run_cmd(2'b10, 6'd0, 16'h0, 0, -1);
      run_cmd(2'b01, 6'd63, 16'h8001, 12, -1);
      run_cmd(2'b10, 6'd63, 16'h0, 0, -1);
      run_cmd(2'b11, 6'd63, 16'h0, 7, -1);
      run_cmd(2'b10, 6'd63, 16'h0, 0, -1);
      // R9: ready never shown, then normal operation resumes
      run_cmd(2'b01, 6'd9, 16'h1234, -1, -1);
      run_cmd(2'b10, 6'd9, 16'h0, 0, -1);
      // R10: request while busy is ignored
      run_cmd(2'b01, 6'd17, 16'h5A5A, 4, 20);
      run_cmd(2'b10, 6'd17, 16'h0, 0, -1);
      // R3: write-all and erase-all
      run_cmd(2'b00, 6'b010101, 16'h6E6E, 9, -1);
      run_cmd(2'b10, 6'd33, 16'h0, 0, -1);
      run_cmd(2'b00, 6'b100000, 16'h0, 2, -1);
      run_cmd(2'b10, 6'd1, 16'h0, 0, -1);

      // random mix
      for (int k = 0; k < 40; k++) begin
         int r;
         logic [1:0] op;
         logic [5:0] a;
         r = int'($urandom_range(0, 9));
         a = 6'($urandom);
         case (r)
            0, 1, 2: op = 2'b10;
            3, 4:    op = 2'b01;
            5:       op = 2'b11;
            6:       begin op = 2'b00; a[5:4] = 2'b11; end
            7:       begin op = 2'b00; a[5:4] = 2'b00; end
            8:       begin op = 2'b00; a[5:4] = 2'b01; end
            default: begin op = 2'b00; a[5:4] = 2'b10; end
         endcase
         run_cmd(op, a, 16'($urandom), int'($urandom_range(0, 40)), -1);
      end

      chk(sk_bad == 0, "R6", "serial clock high phase length", 32'(sk_bad), 0);
      chk(do_bad == 0, "R6", "data-out stable while clock high", 32'(do_bad), 0);

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule